// File: doc/BRIEF.md
# Page Shadow Check-Target Resolver

This block takes a call-target address and reports whether the target is an instrumented location, a trusted location that is allowed through without a check, or an invalid location. For instrumented targets it also returns the address of the check routine of the module that owns the target. The lookup uses a shadow table that holds one 16-bit entry for each 4096-byte page. The entry does not hold a pointer. It holds a distance in pages, measured backwards from the first page boundary at or above the target.

Two entry values are reserved. All ones marks a trusted, unchecked page. Zero marks an invalid page. Any other value V places the check routine (V + 1) pages below the target rounded up to a page boundary. Software loads the table through a write port that takes a page number and a 16-bit value. A lock input models a table that is read-only most of the time. The table is a small direct-mapped RAM that covers a parameterised window of consecutive pages. Every page outside that window reads as invalid.

Top module: `shadow_resolver`

## Requirements
- R1: After reset the response-valid output is low, and every page reads as invalid until it is written.
- R2: A page whose entry is 0xFFFF answers with class 1 (unchecked) and a check address of zero.
- R3: A page whose entry is 0 answers with class 0 (invalid).
- R4: A page whose entry is any other value V answers with class 2 (instrumented). The check address is the target rounded up to the next 4096-byte boundary minus (V + 1) times 4096, modulo 2^64, and it is always 4096-aligned.
- R5: A target that already lies on a 4096-byte boundary rounds up to itself, and any other offset in the page rounds up to the next page.
- R6: The check address output is zero whenever the class is not instrumented.
- R7: A query accepted on a clock edge is answered with response-valid high for exactly the following cycle. Response-valid is low in every cycle that has no accepted query.
- R8: A query to a page outside the window of 2^WIN_IDX_W pages starting at page WIN_BASE_PAGE answers invalid. A write to a page outside the window changes no entry, including the in-window entry that has the same low page bits.
- R9: When a write and a query address the same page on the same edge, the response carries the entry as it was before the write. The next query sees the new value.
- R10: Writes are ignored while the lock input is high.
- R11: The largest distance, entry 0xFFFE, places the check routine 0xFFFF pages (256 MB minus 4096) below the rounded-up target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| lockIn | input | 1 | When high, table writes are discarded |
| wrEn | input | 1 | Table write strobe |
| wrPage | input | 52 | Page number (address bits 63..12) of the entry to write |
| wrData | input | 16 | Shadow value to store |
| qValid | input | 1 | Query strobe |
| qAddr | input | 64 | Call-target address to resolve |
| rValid | output | 1 | Response valid, one cycle after the query |
| rClass | output | 2 | 0 invalid, 1 unchecked, 2 instrumented |
| rCheckAddr | output | 64 | Resolved check-routine address, zero unless instrumented |

## Verification
The embedded properties check four things on every cycle. An instrumented answer is always page-aligned. A non-instrumented answer always carries a zero address. An out-of-window query always comes back invalid. A locked cycle never commits a write. The bench covers what needs scenarios: it sweeps every page of the window at three offsets against arithmetically computed addresses, and it checks the one-cycle response latency. It also checks the old-value result of a same-page write and read, the ignored locked and out-of-window writes observed through later queries, and the largest page distance.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

  typedef enum logic [1:0] {
    CLS_INVALID   = 2'd0,
    CLS_UNCHECKED = 2'd1,
    CLS_INSTR     = 2'd2
  } tgtClass_t;

  typedef struct packed {
    logic wrCommit;
    logic rdAccept;
    logic rdInWin;
  } ctrlStrb_t;

endpackage

// File: rtl/shadow_ctrl.sv
module shadow_ctrl
  import shadow_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int WIN_IDX_W  = 6,
  parameter logic [ADDR_W-PAGE_SHIFT-1:0] WIN_BASE_PAGE = 'h100
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         lockIn,
  input  logic                         wrEn,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] wrPage,
  input  logic                         qValid,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] qPage,
  output ctrlStrb_t                    strb,
  output logic [WIN_IDX_W-1:0]         wrIdx,
  output logic [WIN_IDX_W-1:0]         rdIdx,
  output logic                         rValid
);

  localparam int PW = ADDR_W - PAGE_SHIFT;
  localparam logic [PW-1:0] WIN_PAGES = PW'(1) << WIN_IDX_W;

  logic [PW-1:0] wrOff;
  logic [PW-1:0] rdOff;
  logic          wrInWin;
  logic          rdInWin;

  // Window membership is computed as an offset from the base page, so the
  // base needs no particular alignment.
  always_comb begin
    wrOff   = wrPage - WIN_BASE_PAGE;
    rdOff   = qPage - WIN_BASE_PAGE;
    wrInWin = (wrOff < WIN_PAGES);
    rdInWin = (rdOff < WIN_PAGES);
    wrIdx   = wrOff[WIN_IDX_W-1:0];
    rdIdx   = rdOff[WIN_IDX_W-1:0];
    strb.wrCommit = wrEn && !lockIn && wrInWin;
    strb.rdAccept = qValid;
    strb.rdInWin  = rdInWin;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rValid <= 1'b0;
    else       rValid <= qValid;
  end

  // R10
  lockBlocksWrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockIn |-> !strb.wrCommit);

endmodule

// File: rtl/shadow_dp.sv
module shadow_dp
  import shadow_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int ENTRY_W    = 16,
  parameter int WIN_IDX_W  = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrb_t            strb,
  input  logic [WIN_IDX_W-1:0] wrIdx,
  input  logic [ENTRY_W-1:0]   wrData,
  input  logic [WIN_IDX_W-1:0] rdIdx,
  input  logic [ADDR_W-1:0]    qAddr,
  input  logic                 rValid,
  output logic [1:0]           rClass,
  output logic [ADDR_W-1:0]    rCheckAddr
);

  localparam int PW      = ADDR_W - PAGE_SHIFT;
  localparam int DEPTH   = 1 << WIN_IDX_W;
  localparam logic [ENTRY_W-1:0] ENT_UNCHECKED = '1;
  localparam logic [ENTRY_W-1:0] ENT_INVALID   = '0;

  logic [ENTRY_W-1:0] shadowMem [DEPTH];

  logic [ENTRY_W-1:0] rdEntry;
  logic [PW-1:0]      pageUp;
  logic [ADDR_W-1:0]  roundUp;
  logic [ENTRY_W:0]   distPages;
  logic [ADDR_W-1:0]  distBytes;
  tgtClass_t          nxtClass;
  logic [ADDR_W-1:0]  nxtAddr;
  tgtClass_t          clsQ;
  logic [ADDR_W-1:0]  addrQ;
  logic               outWinQ;

  // Table: reset to invalid, written only on a committed strobe. The read
  // is taken from the array before the edge, so same-edge writes are unseen.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) shadowMem[i] <= ENT_INVALID;
    end else if (strb.wrCommit) begin
      shadowMem[wrIdx] <= wrData;
    end
  end

  always_comb begin
    rdEntry   = strb.rdInWin ? shadowMem[rdIdx] : ENT_INVALID;
    pageUp    = qAddr[ADDR_W-1:PAGE_SHIFT] + PW'(|qAddr[PAGE_SHIFT-1:0]);
    roundUp   = {pageUp, {PAGE_SHIFT{1'b0}}};
    distPages = {1'b0, rdEntry} + (ENTRY_W+1)'(1);
    distBytes = ADDR_W'(distPages) << PAGE_SHIFT;
    nxtAddr   = '0;
    if (rdEntry == ENT_INVALID) begin
      nxtClass = CLS_INVALID;
    end else if (rdEntry == ENT_UNCHECKED) begin
      nxtClass = CLS_UNCHECKED;
    end else begin
      nxtClass = CLS_INSTR;
      nxtAddr  = roundUp - distBytes;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clsQ    <= CLS_INVALID;
      addrQ   <= '0;
      outWinQ <= 1'b0;
    end else if (strb.rdAccept) begin
      clsQ    <= nxtClass;
      addrQ   <= nxtAddr;
      outWinQ <= !strb.rdInWin;
    end
  end

  assign rClass     = clsQ;
  assign rCheckAddr = addrQ;

  // R4
  instrAligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && rClass == CLS_INSTR) |-> (rCheckAddr[PAGE_SHIFT-1:0] == '0));

  // R6
  nonInstrZero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && rClass != CLS_INSTR) |-> (rCheckAddr == '0));

  // R8
  outWindowInvalid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && outWinQ) |-> (rClass == CLS_INVALID));

endmodule

// File: rtl/shadow_resolver.sv
module shadow_resolver
  import shadow_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int ENTRY_W    = 16,
  parameter int WIN_IDX_W  = 6,
  parameter logic [ADDR_W-PAGE_SHIFT-1:0] WIN_BASE_PAGE = 'h100
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         lockIn,
  input  logic                         wrEn,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] wrPage,
  input  logic [ENTRY_W-1:0]           wrData,
  input  logic                         qValid,
  input  logic [ADDR_W-1:0]            qAddr,
  output logic                         rValid,
  output logic [1:0]                   rClass,
  output logic [ADDR_W-1:0]            rCheckAddr
);

  ctrlStrb_t            strb;
  logic [WIN_IDX_W-1:0] wrIdx;
  logic [WIN_IDX_W-1:0] rdIdx;

  shadow_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT),
    .WIN_IDX_W(WIN_IDX_W), .WIN_BASE_PAGE(WIN_BASE_PAGE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .lockIn(lockIn), .wrEn(wrEn), .wrPage(wrPage),
    .qValid(qValid), .qPage(qAddr[ADDR_W-1:PAGE_SHIFT]),
    .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx), .rValid(rValid)
  );

  shadow_dp #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT),
    .ENTRY_W(ENTRY_W), .WIN_IDX_W(WIN_IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrIdx(wrIdx), .wrData(wrData),
    .rdIdx(rdIdx), .qAddr(qAddr), .rValid(rValid),
    .rClass(rClass), .rCheckAddr(rCheckAddr)
  );

endmodule

// File: tb/shadow_resolver_bench.sv
`timescale 1ns/1ps
module shadow_resolver_bench;

  localparam logic [63:0] BASE = 64'h100;
  localparam int          NPG  = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lockIn = 1'b0;
  logic        wrEn = 1'b0;
  logic [51:0] wrPage = '0;
  logic [15:0] wrData = '0;
  logic        qValid = 1'b0;
  logic [63:0] qAddr = '0;
  logic        rValid;
  logic [1:0]  rClass;
  logic [63:0] rCheckAddr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  shadow_resolver u_shadow_resolver (
    .clk(clk), .rstN(rstN), .lockIn(lockIn), .wrEn(wrEn), .wrPage(wrPage),
    .wrData(wrData), .qValid(qValid), .qAddr(qAddr), .rValid(rValid),
    .rClass(rClass), .rCheckAddr(rCheckAddr)
  );

  function automatic logic [15:0] pat(int i);
    if (i == 0) return 16'h0000;
    if (i == 1) return 16'hFFFF;
    if (i == 2) return 16'hFFFE;
    return 16'(i * 997 + 3);
  endfunction

  function automatic logic [1:0] expCls(logic [15:0] v);
    if (v == 16'h0000) return 2'd0;
    if (v == 16'hFFFF) return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic [63:0] expAddr(logic [63:0] a, logic [15:0] v);
    if (expCls(v) != 2'd2) return 64'd0;
    return ((a + 64'd4095) & ~64'hFFF) - ((64'(v) + 64'd1) << 12);
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(logic [63:0] page, logic [15:0] v);
    @(negedge clk);
    wrEn = 1'b1; wrPage = page[51:0]; wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Query, check response the following cycle, then check valid drops.
  task automatic doQuery(logic [63:0] a, logic [15:0] v, string req);
    @(negedge clk);
    qValid = 1'b1; qAddr = a;
    @(negedge clk);
    qValid = 1'b0;
    chk(rValid === 1'b1, "R7 valid", 64'(rValid), 64'd1);
    chk(rClass === expCls(v), req, 64'(rClass), 64'(expCls(v)));
    chk(rCheckAddr === expAddr(a, v), req, rCheckAddr, expAddr(a, v));
    @(negedge clk);
    chk(rValid === 1'b0, "R7 drop", 64'(rValid), 64'd0);
  endtask

  function automatic string reqOf(logic [15:0] v);
    if (v == 16'h0000) return "R3 invalid";
    if (v == 16'hFFFF) return "R2 R6 unchecked";
    if (v == 16'hFFFE) return "R11 max distance";
    return "R4 R5 instrumented";
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rValid === 1'b0, "R1 reset valid", 64'(rValid), 64'd0);
    rstN = 1'b1;
    doQuery((BASE + 5) << 12, 16'h0000, "R1 reset invalid");
    doQuery(((BASE + 63) << 12) + 64'h7, 16'h0000, "R1 reset invalid");

    for (int i = 0; i < NPG; i++) doWrite(BASE + 64'(i), pat(i));
    for (int i = 0; i < NPG; i++) begin
      logic [63:0] pa;
      pa = (BASE + 64'(i)) << 12;
      doQuery(pa,             pat(i), reqOf(pat(i)));
      doQuery(pa + 64'd1,     pat(i), reqOf(pat(i)));
      doQuery(pa + 64'hFFF,   pat(i), reqOf(pat(i)));
    end

    // R8: outside the window
    doQuery((BASE - 1) << 12, 16'h0000, "R8 below window");
    doQuery((BASE + 64) << 12, 16'h0000, "R8 above window");
    doWrite(BASE + 64 + 5, 16'h1234);
    doQuery((BASE + 5) << 12, pat(5), "R8 alias write ignored");

    // R10: locked write
    lockIn = 1'b1;
    doWrite(BASE + 3, 16'h0777);
    lockIn = 1'b0;
    doQuery(((BASE + 3) << 12) + 64'h20, pat(3), "R10 locked write ignored");

    // R9: same-edge write and query
    @(negedge clk);
    wrEn = 1'b1; wrPage = 52'(BASE + 4); wrData = 16'h0010;
    qValid = 1'b1; qAddr = ((BASE + 4) << 12) + 64'h80;
    @(negedge clk);
    wrEn = 1'b0; qValid = 1'b0;
    chk(rClass === expCls(pat(4)), "R9 old class", 64'(rClass), 64'(expCls(pat(4))));
    chk(rCheckAddr === expAddr(((BASE + 4) << 12) + 64'h80, pat(4)), "R9 old addr",
        rCheckAddr, expAddr(((BASE + 4) << 12) + 64'h80, pat(4)));
    doQuery(((BASE + 4) << 12) + 64'h80, 16'h0010, "R9 new value");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule